// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address, issued under a 12-bit address-space number, into a 36-bit physical address. It walks the translation tables in memory. A root register gives the base of a 4096-slot root table. The address-space number picks one root slot. That slot must point to a first-level table, indexed by the top eight virtual address bits. Two more levels follow, each indexed by six bits. The final word must be a leaf entry, which carries the physical page number and the control bits.

Each table word carries a two-bit kind code in its lowest bits. The code marks the word as a pointer to the next table, a leaf entry, or a hole. The walk may fail in two ways. A validation failure covers holes, reserved codes and leaves that sit at the wrong depth. A protection failure covers accesses that the leaf's permission code does not allow. A successful leaf whose used bit is clear is written back with that bit set, and so is a leaf whose dirty bit is clear on a write. The write-back happens before the result is reported.

The requester, typically a translation-cache refill path, starts one walk at a time and waits for a completion pulse. Memory is reached through a single word port with a request/acknowledge pair.

Top module: `tablewalk_top`

## Requirements
- R1: After reset, busy, done, memRd and memWr are 0 and faultCode is 00.
- R2: A reqValid sampled while busy is 0 starts a walk. busy then stays 1 until done has been 1 for exactly one cycle, and it drops after that cycle. A reqValid sampled while busy is 1 is ignored.
- R3: memRd and memWr are never 1 together. A raised request holds its address and data stable until memAck is seen.
- R4: The root word is read from {ctxTablePtr, 4'b0} + 4*ctxId. A word of kind pointer gives the next base as {2'b00, word[31:2], 4'b0000}. The next word is read at base + 4*index, where the first-level index is vaddr[31:24], the second-level index is vaddr[23:18] and the third-level index is vaddr[17:12]. A successful walk makes exactly four reads.
- R5: word[1:0] codes are 00 hole, 01 pointer, 10 leaf and 11 reserved. A hole or a reserved code at any level ends the walk with faultCode 01 (validation).
- R6: A leaf met at the root or at levels 1 to 2 gives faultCode 01. So does a pointer met at level 3.
- R7: A leaf's permission code is word[4:2]. Reads are allowed for codes 0, 1, 2, 3, 5 and 6. Writes are allowed for codes 1, 3 and 6. A disallowed access gives faultCode 10 (protection) and causes no memory write.
- R8: On a permitted leaf, used bit word[5] is checked, and on a write the dirty bit word[6] is checked too. If either is clear, the leaf is written back with bit 5 set (and bit 6 set on a write) before done. Otherwise no write occurs.
- R9: On success, faultCode is 00, paddr is {word[31:8], vaddr[11:0]} and pteOut is the leaf as finally stored.
- R10: On a fault, paddr is 0 and pteOut is the word that caused the fault. The results stay valid from done until the next walk starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| ctxTablePtr | input | 32 | Root table base, in 16-byte units |
| ctxId | input | 12 | Address-space number selecting the root slot |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| faultCode | output | 2 | 00 none, 01 validation, 10 protection |
| paddr | output | 36 | Translated physical address |
| pteOut | output | 32 | Final leaf or faulting word |
| memRd | output | 1 | Word read request |
| memWr | output | 1 | Word write request |
| memAddr | output | 36 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Memory completes the current request |

## Verification
The properties assume the following about the inputs. memAck only comes while a request is raised. memRdata is valid in the cycle memAck is high. The root pointer and address-space number stay steady while a walk starts.

The bench memory model meets these assumptions. It answers one cycle after a request appears and drops its acknowledge right away. Every table used is built in memory before the walk that reads it, and the bench changes reqVaddr in the middle of a walk only to show that a busy walker ignores it.

// File: rtl/tablewalk_pkg.sv
package tablewalk_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int CTX_W  = 12;
  localparam int OFF_W  = 12;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int WORD_W = 32;
  localparam int L1_HI  = 31;
  localparam int L1_LO  = 24;
  localparam int L2_HI  = 23;
  localparam int L2_LO  = 18;
  localparam int L3_HI  = 17;
  localparam int L3_LO  = 12;
  localparam int LAST_LEVEL = 3;

  typedef enum logic [1:0] {
    KIND_HOLE = 2'b00,
    KIND_PTR  = 2'b01,
    KIND_LEAF = 2'b10,
    KIND_RSVD = 2'b11
  } kind_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_VALID = 2'b01,
    FLT_PROT  = 2'b10
  } fault_t;

  typedef struct packed {
    logic   loadReq;
    logic   captureWord;
    logic   stepLevel;
    logic   setResult;
    fault_t resCode;
  } strobes_t;

  function automatic logic permAllows(input logic [2:0] acc, input logic isWrite);
    logic rdOk;
    logic wrOk;
    rdOk = !(acc == 3'd4 || acc == 3'd7);
    wrOk = (acc == 3'd1 || acc == 3'd3 || acc == 3'd6);
    return isWrite ? wrOk : rdOk;
  endfunction
endpackage

// File: rtl/tablewalk_dp.sv
module tablewalk_dp
  import tablewalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [31:0]       ctxTablePtr,
  input  logic [CTX_W-1:0]  ctxId,
  input  logic [WORD_W-1:0] memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [1:0]        levelQ,
  output kind_t             wordKind,
  output logic              permOk,
  output logic              needUpdate,
  output logic [1:0]        faultCode,
  output logic [PA_W-1:0]   paddr,
  output logic [WORD_W-1:0] pteOut
);
  localparam int PAD_W = PA_W - CTX_W - 2;

  logic [VA_W-1:0]   vaQ;
  logic              writeQ;
  logic [CTX_W-1:0]  ctxQ;
  logic [PA_W-1:0]   baseQ;
  logic [WORD_W-1:0] wordQ;
  logic [CTX_W-1:0]  idx;
  logic [WORD_W-1:0] updatedWord;

  always_comb begin
    unique case (levelQ)
      2'd0:    idx = ctxQ;
      2'd1:    idx = CTX_W'(vaQ[L1_HI:L1_LO]);
      2'd2:    idx = CTX_W'(vaQ[L2_HI:L2_LO]);
      default: idx = CTX_W'(vaQ[L3_HI:L3_LO]);
    endcase
  end

  assign memAddr     = baseQ + {{PAD_W{1'b0}}, idx, 2'b00};
  assign wordKind    = kind_t'(wordQ[1:0]);
  assign permOk      = permAllows(wordQ[4:2], writeQ);
  assign needUpdate  = !wordQ[5] || (writeQ && !wordQ[6]);
  assign updatedWord = wordQ | 32'h20 | (writeQ ? 32'h40 : 32'h0);
  assign memWdata    = updatedWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      writeQ    <= 1'b0;
      ctxQ      <= '0;
      baseQ     <= '0;
      levelQ    <= '0;
      wordQ     <= '0;
      faultCode <= FLT_NONE;
      paddr     <= '0;
      pteOut    <= '0;
    end else begin
      if (stb.loadReq) begin
        vaQ    <= reqVaddr;
        writeQ <= reqWrite;
        ctxQ   <= ctxId;
        baseQ  <= {ctxTablePtr, 4'b0000};
        levelQ <= 2'd0;
      end
      if (stb.captureWord) wordQ <= memRdata;
      if (stb.stepLevel) begin
        baseQ  <= {2'b00, wordQ[WORD_W-1:2], 4'b0000};
        levelQ <= levelQ + 2'd1;
      end
      if (stb.setResult) begin
        faultCode <= stb.resCode;
        if (stb.resCode == FLT_NONE) begin
          paddr  <= {wordQ[WORD_W-1:8], vaQ[OFF_W-1:0]};
          pteOut <= updatedWord;
        end else begin
          paddr  <= '0;
          pteOut <= wordQ;
        end
      end
    end
  end
endmodule

// File: rtl/tablewalk_ctrl.sv
module tablewalk_ctrl
  import tablewalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memAck,
  input  logic [1:0] levelQ,
  input  kind_t      wordKind,
  input  logic       permOk,
  input  logic       needUpdate,
  output logic       busy,
  output logic       done,
  output logic       memRd,
  output logic       memWr,
  output strobes_t   stb
);
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_EVAL, ST_WRITE, ST_DONE} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '{loadReq: 1'b0, captureWord: 1'b0, stepLevel: 1'b0,
               setResult: 1'b0, resCode: FLT_NONE};
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1;
        stateD      = ST_READ;
      end
      ST_READ: if (memAck) begin
        stb.captureWord = 1'b1;
        stateD          = ST_EVAL;
      end
      ST_EVAL: begin
        if (wordKind == KIND_PTR && levelQ != 2'(LAST_LEVEL)) begin
          stb.stepLevel = 1'b1;
          stateD        = ST_READ;
        end else if (wordKind == KIND_LEAF && levelQ == 2'(LAST_LEVEL)) begin
          if (!permOk) begin
            stb.setResult = 1'b1;
            stb.resCode   = FLT_PROT;
            stateD        = ST_DONE;
          end else if (needUpdate) begin
            stateD = ST_WRITE;
          end else begin
            stb.setResult = 1'b1;
            stateD        = ST_DONE;
          end
        end else begin
          stb.setResult = 1'b1;
          stb.resCode   = FLT_VALID;
          stateD        = ST_DONE;
        end
      end
      ST_WRITE: if (memAck) begin
        stb.setResult = 1'b1;
        stateD        = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy  = (stateQ != ST_IDLE);
  assign done  = (stateQ == ST_DONE);
  assign memRd = (stateQ == ST_READ);
  assign memWr = (stateQ == ST_WRITE);
endmodule

// File: rtl/tablewalk_top.sv
module tablewalk_top
  import tablewalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [31:0]       ctxTablePtr,
  input  logic [CTX_W-1:0]  ctxId,
  output logic              busy,
  output logic              done,
  output logic [1:0]        faultCode,
  output logic [PA_W-1:0]   paddr,
  output logic [WORD_W-1:0] pteOut,
  output logic              memRd,
  output logic              memWr,
  output logic [PA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck
);
  strobes_t   stb;
  logic [1:0] levelQ;
  kind_t      wordKind;
  logic       permOk;
  logic       needUpdate;

  tablewalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .levelQ(levelQ), .wordKind(wordKind), .permOk(permOk), .needUpdate(needUpdate),
    .busy(busy), .done(done), .memRd(memRd), .memWr(memWr), .stb(stb)
  );

  tablewalk_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .ctxTablePtr(ctxTablePtr), .ctxId(ctxId), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .levelQ(levelQ), .wordKind(wordKind),
    .permOk(permOk), .needUpdate(needUpdate), .faultCode(faultCode),
    .paddr(paddr), .pteOut(pteOut)
  );
endmodule

// File: rtl/tablewalk_chk.sv
module tablewalk_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        done,
  input logic [1:0]  faultCode,
  input logic        memRd,
  input logic        memWr,
  input logic [35:0] memAddr,
  input logic [31:0] memWdata,
  input logic        memAck
);
  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_port_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_read_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAck) |=> (memRd && $stable(memAddr)));

  assert_write_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memAck) |=> (memWr && $stable(memAddr) && $stable(memWdata)));

  assert_writeback_used_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> memWdata[5]);

  assert_no_write_after_prot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode == 2'b10) |-> !memWr);
endmodule

bind tablewalk_top tablewalk_chk u_chk (.*);

// File: tb/tb_tablewalk_top.sv
module tb_tablewalk_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] ctxTablePtr = 32'h0000_1000;
  logic [11:0] ctxId = 12'd5;
  logic        busy, done, memRd, memWr, memAck;
  logic [1:0]  faultCode;
  logic [35:0] paddr, memAddr;
  logic [31:0] pteOut, memWdata, memRdata;

  int checks = 0;
  int failures = 0;
  int readCount = 0;
  int writeCount = 0;
  int portErrors = 0;
  logic [35:0] readLog [0:7];
  logic [31:0] mem [logic [35:0]];
  logic prevRd = 1'b0;
  logic prevAck = 1'b0;
  logic [35:0] prevAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tablewalk_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .ctxTablePtr(ctxTablePtr), .ctxId(ctxId),
    .busy(busy), .done(done), .faultCode(faultCode), .paddr(paddr), .pteOut(pteOut),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  // memory model: one-cycle latency, single-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= (memRd || memWr) && !memAck;
      if (memRd && !memAck) begin
        memRdata <= mem.exists(memAddr) ? mem[memAddr] : 32'h0;
        if (readCount < 8) readLog[readCount] = memAddr;
        readCount++;
      end
      if (memWr && !memAck) begin
        mem[memAddr] = memWdata;
        writeCount++;
      end
      if (memRd && memWr) portErrors++;
      if (prevRd && !prevAck && (!memRd || memAddr != prevAddr)) portErrors++;
      prevRd   <= memRd;
      prevAck  <= memAck;
      prevAddr <= memAddr;
    end
  end

  localparam logic [35:0] ROOT = 36'h0_0001_0000;
  localparam logic [35:0] L1B  = 36'h0_0002_0000;
  localparam logic [35:0] L2B  = 36'h0_0003_0000;
  localparam logic [35:0] L3B  = 36'h0_0004_0000;

  function automatic logic [31:0] mkPtr(input logic [35:0] base);
    return {base[33:4], 2'b01};
  endfunction
  function automatic logic [31:0] mkLeaf(input logic [23:0] ppn, input logic m,
                                         input logic r, input logic [2:0] acc);
    return {ppn, 1'b0, m, r, acc, 2'b10};
  endfunction
  function automatic logic [31:0] va(input logic [7:0] i1, input logic [5:0] i2,
                                     input logic [5:0] i3, input logic [11:0] off);
    return {i1, i2, i3, off};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] addr, input logic wr);
    int n;
    readCount  = 0;
    writeCount = 0;
    @(negedge clk);
    reqVaddr = addr;
    reqWrite = wr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(1'b0, "R2 walk timeout", 64'(n), 64'd500);
  endtask

  task automatic testReset();
    check(!busy && !done && !memRd && !memWr && faultCode == 2'b00, "R1 reset state",
          {busy, done, memRd, memWr, faultCode}, 64'd0);
  endtask

  task automatic testHitNoUpdate();
    logic [31:0] a;
    a = va(8'h12, 6'h05, 6'd3, 12'h9AB);
    mem[L3B + 36'd12] = mkLeaf(24'hABCDEF, 1'b0, 1'b1, 3'd1);
    runWalk(a, 1'b0);
    check(faultCode == 2'b00, "R9 fault code", 64'(faultCode), 64'd0);
    check(paddr == 36'hABCDEF9AB, "R9 paddr", 64'(paddr), 64'hABCDEF9AB);
    check(pteOut == mkLeaf(24'hABCDEF, 1'b0, 1'b1, 3'd1), "R9 pteOut", 64'(pteOut),
          64'(mkLeaf(24'hABCDEF, 1'b0, 1'b1, 3'd1)));
    check(writeCount == 0, "R8 no write when used set", 64'(writeCount), 64'd0);
    check(readCount == 4, "R4 read count", 64'(readCount), 64'd4);
    check(readLog[0] == ROOT + 36'd20, "R4 root addr", 64'(readLog[0]), 64'(ROOT + 36'd20));
    check(readLog[1] == L1B + 36'h48, "R4 level1 addr", 64'(readLog[1]), 64'(L1B + 36'h48));
    check(readLog[2] == L2B + 36'd20, "R4 level2 addr", 64'(readLog[2]), 64'(L2B + 36'd20));
    check(readLog[3] == L3B + 36'd12, "R4 level3 addr", 64'(readLog[3]), 64'(L3B + 36'd12));
    @(negedge clk);
    check(!done && !busy, "R2 done one cycle", {done, busy}, 64'd0);
  endtask

  task automatic testUsedUpdate();
    mem[L3B + 36'd16] = mkLeaf(24'h000111, 1'b0, 1'b0, 3'd0);
    runWalk(va(8'h12, 6'h05, 6'd4, 12'h004), 1'b0);
    check(writeCount == 1, "R8 used write count", 64'(writeCount), 64'd1);
    check(mem[L3B + 36'd16] == mkLeaf(24'h000111, 1'b0, 1'b1, 3'd0), "R8 used bit stored",
          64'(mem[L3B + 36'd16]), 64'(mkLeaf(24'h000111, 1'b0, 1'b1, 3'd0)));
    check(pteOut == mkLeaf(24'h000111, 1'b0, 1'b1, 3'd0), "R9 updated pteOut",
          64'(pteOut), 64'(mkLeaf(24'h000111, 1'b0, 1'b1, 3'd0)));
  endtask

  task automatic testDirtyUpdate();
    mem[L3B + 36'd20] = mkLeaf(24'h222333, 1'b0, 1'b1, 3'd3);
    runWalk(va(8'h12, 6'h05, 6'd5, 12'hFFF), 1'b1);
    check(writeCount == 1, "R8 dirty write count", 64'(writeCount), 64'd1);
    check(mem[L3B + 36'd20] == mkLeaf(24'h222333, 1'b1, 1'b1, 3'd3), "R8 dirty bit stored",
          64'(mem[L3B + 36'd20]), 64'(mkLeaf(24'h222333, 1'b1, 1'b1, 3'd3)));
    check(paddr == 36'h222333FFF && faultCode == 2'b00, "R9 write paddr", 64'(paddr),
          64'h222333FFF);
  endtask

  task automatic testProtection();
    for (int acc = 0; acc < 8; acc++) begin
      for (int w = 0; w < 2; w++) begin
        logic ok;
        logic [31:0] leaf;
        ok = (w == 1) ? (acc == 1 || acc == 3 || acc == 6) : !(acc == 4 || acc == 7);
        leaf = mkLeaf(24'h0000AA + 24'(acc), 1'b1, 1'b1, 3'(acc));
        mem[L3B + 36'd40] = leaf;
        runWalk(va(8'h12, 6'h05, 6'd10, 12'h010), w[0]);
        check(faultCode == (ok ? 2'b00 : 2'b10), "R7 permission table",
              {32'(acc), 30'd0, faultCode}, {32'(acc), 30'd0, ok ? 2'b00 : 2'b10});
        if (!ok) begin
          check(writeCount == 0 && paddr == 36'd0, "R10 protection no write, paddr 0",
                {32'(writeCount), 32'(paddr)}, 64'd0);
          check(pteOut == leaf, "R10 faulting word", 64'(pteOut), 64'(leaf));
        end
      end
    end
    mem[L3B + 36'd40] = mkLeaf(24'h00BBBB, 1'b0, 1'b1, 3'd0);
    runWalk(va(8'h12, 6'h05, 6'd10, 12'h010), 1'b1);
    check(faultCode == 2'b10 && writeCount == 0, "R7 protection beats dirty update",
          {32'(writeCount), 30'd0, faultCode}, 64'd2);
  endtask

  task automatic testValidation();
    ctxId = 12'd9;
    runWalk(va(8'h12, 6'h05, 6'd3, 12'h0), 1'b0);
    check(faultCode == 2'b01 && readCount == 1, "R5 hole at root",
          {32'(readCount), 30'd0, faultCode}, {32'd1, 32'd1});
    check(paddr == 36'd0 && pteOut == 32'd0, "R10 hole word reported", 64'(pteOut), 64'd0);
    ctxId = 12'd5;
    mem[L2B + 36'(6'h2A * 4)] = 32'h0000_0007;
    runWalk(va(8'h12, 6'h2A, 6'd3, 12'h0), 1'b0);
    check(faultCode == 2'b01 && readCount == 3, "R5 reserved code at level2",
          {32'(readCount), 30'd0, faultCode}, {32'd3, 32'd1});
    check(pteOut == 32'h7, "R10 reserved word reported", 64'(pteOut), 64'h7);
    mem[L1B + 36'(8'h77 * 4)] = mkLeaf(24'h123456, 1'b1, 1'b1, 3'd1);
    runWalk(va(8'h77, 6'h00, 6'd0, 12'h0), 1'b0);
    check(faultCode == 2'b01 && readCount == 2, "R6 leaf at level1",
          {32'(readCount), 30'd0, faultCode}, {32'd2, 32'd1});
    mem[L3B + 36'd240] = mkPtr(L3B);
    runWalk(va(8'h12, 6'h05, 6'd60, 12'h0), 1'b0);
    check(faultCode == 2'b01 && readCount == 4, "R6 pointer at level3",
          {32'(readCount), 30'd0, faultCode}, {32'd4, 32'd1});
    mem[ROOT + 36'd44] = mkLeaf(24'h000001, 1'b1, 1'b1, 3'd1);
    ctxId = 12'd11;
    runWalk(va(8'h12, 6'h05, 6'd3, 12'h0), 1'b0);
    check(faultCode == 2'b01 && readCount == 1, "R6 leaf at root",
          {32'(readCount), 30'd0, faultCode}, {32'd1, 32'd1});
    ctxId = 12'd5;
  endtask

  task automatic testBusyIgnore();
    int n;
    mem[L3B + 36'd4] = mkLeaf(24'h00A00A, 1'b1, 1'b1, 3'd1);
    mem[L3B + 36'd8] = mkLeaf(24'h00B00B, 1'b1, 1'b1, 3'd1);
    readCount = 0;
    @(negedge clk);
    reqVaddr = va(8'h12, 6'h05, 6'd1, 12'h111);
    reqWrite = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(busy, "R2 busy during walk", 64'(busy), 64'd1);
    reqVaddr = va(8'h12, 6'h05, 6'd2, 12'h222);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(paddr == 36'h00A00A111, "R2 mid-walk request ignored", 64'(paddr), 64'h00A00A111);
    repeat (6) @(negedge clk);
    check(!busy && readCount == 4, "R2 no second walk", {32'(busy), 32'(readCount)}, 64'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem[ROOT + 36'd20]          = mkPtr(L1B);
    mem[L1B + 36'(8'h12 * 4)]   = mkPtr(L2B);
    mem[L2B + 36'(6'h05 * 4)]   = mkPtr(L3B);
    mem[L2B + 36'(6'h00 * 4)]   = 32'h0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHitNoUpdate();
    testUsedUpdate();
    testDirtyUpdate();
    testProtection();
    testValidation();
    testBusyIgnore();
    check(portErrors == 0, "R3 port exclusive and held", 64'(portErrors), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule